// File: doc/BRIEF.md
# Consumer data-hold watchdog

This block watches up to eight cyclic receive connections, called consumers. Each consumer has a hold timer that counts down in send cycles. A valid-frame strobe for the consumer reloads its timer. The timer advances only on a send-cycle tick that arrives from outside the block. If a consumer's timer runs out, the block:

- drops that consumer's run status,
- sets its sticky expire flag,
- queues a notification with event code 0x01,
- withdraws every provider that belongs to the consumer's relation group.

Group membership comes from a per-group inverted provider mask.

The host configures the block through a byte-wide write port. It sets per-consumer timeouts, activation bits, relation-group numbers and the inverted group masks. It also writes the provider-active bits and their shadow copies. A list-swap strobe copies the shadow bits into the live provider-active bits.

Receive-error strobes (CRC, sequence counter, data status) from active consumers are queued as further event codes. The block posts at most one event per clock.

Top module: `hold_watchdog`

## Requirements
- R1: After reset these values hold: every timer holds 3, every consumer status is 1 (run), every expire flag is 0, every provider-active and shadow bit is 0, every group mask is 0xFF, every group number is 0, every activation bit is 0, and `evtValid` is 0.
- R2: A host write addresses a register through `hostAddr[5:3]` (region) and `hostAddr[2:0]` (index). The regions are:
  - 0: timeout of consumer idx.
  - 1: activation byte, idx 0 only, bit i for consumer i.
  - 2: group number of consumer idx, data[2:0].
  - 3: inverted provider mask of group idx.
  - 4: provider-active bit idx, data[0].
  - 5: provider shadow bit idx, data[0].

  Region 1 with a nonzero idx, and regions 6 and 7, change nothing.
- R3: While a consumer is inactive, its timer is held at its timeout and it never expires. Its frame strobes and error strobes have no effect. A 0-to-1 write of its activation bit clears its expire flag and sets its status to 1 at that same edge.
- R4: An active consumer expires on the tick that finds its timer at 1 or 0 while its status is 1. That is the T-th tick after a reload with timeout T, and a timeout of 0 behaves like 1. Status reads 0 and the expire flag reads 1 right after that edge. A failed consumer does not expire again until it is reloaded.
- R5: A valid-frame strobe on an active consumer reloads its timer and sets its status to 1, even when a tick arrives in the same cycle. The expire flag stays set.
- R6: At the edge where consumer i expires, every provider p whose bit p is 0 in the mask of group `grp[i]` has its active bit cleared.
- R7: A provider cleared by an expiry also has its shadow bit cleared. This clear wins over a host write or a list swap in the same cycle. A list swap copies every shadow bit into its active bit.
- R8: Expiry posts event code 0x01, a CRC error posts 0x02, a sequence error posts 0x03 and a status error posts 0x04. Causes are queued per code and per consumer, and identical causes merge. One event is output per clock, lowest code first, then lowest consumer index. `evtValid`, `evtCode` and `evtCons` are valid the cycle after the edge that queued the cause.
- R9: CRC, sequence and status error strobes of inactive consumers are not queued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hostWe | input | 1 | Host write strobe |
| hostAddr | input | 6 | Host register address (region, index) |
| hostWdata | input | 8 | Host write data |
| listSwap | input | 1 | Copy shadow provider bits into active bits |
| cycleTick | input | 1 | One-clock send-cycle tick |
| frameOk | input | 8 | Per-consumer valid-frame strobe |
| crcErr | input | 8 | Per-consumer CRC error strobe |
| seqErr | input | 8 | Per-consumer sequence counter error strobe |
| statErr | input | 8 | Per-consumer data status error strobe |
| consStatus | output | 8 | Per-consumer status, 1 = run, 0 = failed |
| expireFlags | output | 8 | Per-consumer sticky expire flag |
| provActive | output | 8 | Per-provider active bit |
| evtValid | output | 1 | Notification valid this cycle |
| evtCode | output | 8 | Notification code |
| evtCons | output | 3 | Consumer index of the notification |

## Verification
The consumer status, the expire flags and the provider bits change at the same edge that samples a tick, a frame, a swap or a host write. They are therefore due one edge after the stimulus cycle. A notification is due one edge later still, because the cause is first queued and then posted.

A behavioural model in the bench advances at each rising edge from the same inputs, following those latencies. It is compared with every output at each falling edge, so each check samples a settled value.

The directed checks cover these cases at the cycles where they are due:
- a zero timeout,
- a frame and a tick in the same cycle,
- an expiry in the same cycle as a list swap,
- reactivation,
- the order in which queued events are posted.

// File: rtl/hold_wd_pkg.sv
package hold_wd_pkg;
  localparam int NUM_CONS  = 8;
  localparam int NUM_PROV  = 8;
  localparam int NUM_GRP   = 8;
  localparam int TMO_W     = 8;
  localparam int NUM_CODES = 4;
  localparam int CIDX_W    = $clog2(NUM_CONS);
  localparam int PIDX_W    = $clog2(NUM_PROV);
  localparam int GRP_W     = $clog2(NUM_GRP);
  localparam int CODE_W    = $clog2(NUM_CODES);
  localparam int IDX_W     = (CIDX_W > PIDX_W) ? CIDX_W : PIDX_W;
  localparam int REGION_W  = 3;
  localparam int ADDR_W    = REGION_W + IDX_W;

  // host register regions (upper address bits)
  localparam logic [REGION_W-1:0] RG_TMO  = 3'd0;
  localparam logic [REGION_W-1:0] RG_ACT  = 3'd1;
  localparam logic [REGION_W-1:0] RG_GRP  = 3'd2;
  localparam logic [REGION_W-1:0] RG_MASK = 3'd3;
  localparam logic [REGION_W-1:0] RG_PACT = 3'd4;
  localparam logic [REGION_W-1:0] RG_PSHD = 3'd5;

  // notification codes, consecutive so the arbiter index maps directly
  localparam logic [7:0] EVT_EXPIRE = 8'h01;
  localparam logic [7:0] EVT_CRC    = 8'h02;
  localparam logic [7:0] EVT_SEQ    = 8'h03;
  localparam logic [7:0] EVT_STAT   = 8'h04;

  // strobes from control to datapath
  typedef struct packed {
    logic [NUM_CONS-1:0] active;    // activation bits
    logic [NUM_CONS-1:0] actRise;   // activation 0->1 this cycle
    logic [NUM_PROV-1:0] provWr;    // host writes provider-active bit
    logic [NUM_PROV-1:0] shadowWr;  // host writes provider shadow bit
    logic                wrBit;     // value written
    logic                swap;      // shadow -> active copy
    logic [NUM_PROV-1:0] killMask;  // providers withdrawn by expiry
  } wdStrobes_t;
endpackage

// File: rtl/hold_wd_ctrl.sv
module hold_wd_ctrl
  import hold_wd_pkg::*;
#(
  parameter logic [TMO_W-1:0]    TMO_RESET  = TMO_W'(3),
  parameter logic [NUM_PROV-1:0] MASK_RESET = '1
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      hostWe,
  input  logic [ADDR_W-1:0]         hostAddr,
  input  logic [7:0]                hostWdata,
  input  logic                      listSwap,
  input  logic [NUM_CONS-1:0]       crcErr,
  input  logic [NUM_CONS-1:0]       seqErr,
  input  logic [NUM_CONS-1:0]       statErr,
  input  logic [NUM_CONS-1:0]       expireNow,
  output wdStrobes_t                strb,
  output logic [NUM_CONS*TMO_W-1:0] tmoFlat,
  output logic                      evtValid,
  output logic [7:0]                evtCode,
  output logic [CIDX_W-1:0]         evtCons
);
  logic [TMO_W-1:0]    tmoReg  [NUM_CONS];
  logic [GRP_W-1:0]    grpReg  [NUM_CONS];
  logic [NUM_PROV-1:0] maskReg [NUM_GRP];
  logic [NUM_CONS-1:0] actReg;

  logic [REGION_W-1:0] wrRegion;
  logic [IDX_W-1:0]    wrIdx;
  logic                actWrite;

  assign wrRegion = hostAddr[ADDR_W-1:IDX_W];
  assign wrIdx    = hostAddr[IDX_W-1:0];
  assign actWrite = hostWe && (wrRegion == RG_ACT) && (wrIdx == '0);

  // ---------------- configuration registers ----------------
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_CONS; i++) begin
        tmoReg[i] <= TMO_RESET;
        grpReg[i] <= '0;
      end
      for (int g = 0; g < NUM_GRP; g++) maskReg[g] <= MASK_RESET;
      actReg <= '0;
    end else if (hostWe) begin
      for (int i = 0; i < NUM_CONS; i++) begin
        if (wrRegion == RG_TMO && wrIdx == IDX_W'(i)) tmoReg[i] <= hostWdata[TMO_W-1:0];
        if (wrRegion == RG_GRP && wrIdx == IDX_W'(i)) grpReg[i] <= hostWdata[GRP_W-1:0];
      end
      for (int g = 0; g < NUM_GRP; g++)
        if (wrRegion == RG_MASK && wrIdx == IDX_W'(g)) maskReg[g] <= hostWdata[NUM_PROV-1:0];
      if (actWrite) actReg <= hostWdata[NUM_CONS-1:0];
    end
  end

  generate
    for (genvar gi = 0; gi < NUM_CONS; gi++) begin : g_tmo
      assign tmoFlat[gi*TMO_W +: TMO_W] = tmoReg[gi];
    end
  endgenerate

  // ---------------- strobes toward the datapath ----------------
  always_comb begin
    strb.active  = actReg;
    strb.actRise = actWrite ? (hostWdata[NUM_CONS-1:0] & ~actReg) : '0;
    strb.wrBit   = hostWdata[0];
    strb.swap    = listSwap;
    for (int p = 0; p < NUM_PROV; p++) begin
      strb.provWr[p]   = hostWe && (wrRegion == RG_PACT) && (wrIdx == IDX_W'(p));
      strb.shadowWr[p] = hostWe && (wrRegion == RG_PSHD) && (wrIdx == IDX_W'(p));
    end
    // inverted mask: a zero bit marks a member provider
    strb.killMask = '0;
    for (int i = 0; i < NUM_CONS; i++)
      if (expireNow[i]) strb.killMask = strb.killMask | ~maskReg[grpReg[i]];
  end

  // ---------------- notification queue ----------------
  logic [NUM_CONS-1:0] pend   [NUM_CODES];
  logic [NUM_CONS-1:0] newEv  [NUM_CODES];
  logic [NUM_CONS-1:0] clrVec [NUM_CODES];
  logic                selFound;
  logic [CODE_W-1:0]   selCode;
  logic [CIDX_W-1:0]   selIdx;

  always_comb begin
    newEv[0] = expireNow;
    newEv[1] = crcErr  & actReg;
    newEv[2] = seqErr  & actReg;
    newEv[3] = statErr & actReg;
  end

  always_comb begin
    selFound = 1'b0;
    selCode  = '0;
    selIdx   = '0;
    for (int c = 0; c < NUM_CODES; c++)
      for (int i = 0; i < NUM_CONS; i++)
        if (!selFound && pend[c][i]) begin
          selFound = 1'b1;
          selCode  = CODE_W'(c);
          selIdx   = CIDX_W'(i);
        end
    for (int c = 0; c < NUM_CODES; c++)
      clrVec[c] = (selFound && selCode == CODE_W'(c)) ? (NUM_CONS'(1) << selIdx) : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int c = 0; c < NUM_CODES; c++) pend[c] <= '0;
      evtValid <= 1'b0;
      evtCode  <= '0;
      evtCons  <= '0;
    end else begin
      for (int c = 0; c < NUM_CODES; c++) pend[c] <= (pend[c] & ~clrVec[c]) | newEv[c];
      evtValid <= selFound;
      evtCode  <= selFound ? (EVT_EXPIRE + 8'(selCode)) : '0;
      evtCons  <= selFound ? selIdx : '0;
    end
  end

  logic anyPend;
  always_comb begin
    anyPend = 1'b0;
    for (int c = 0; c < NUM_CODES; c++) anyPend = anyPend | (|pend[c]);
  end

  AST_EVT_CODE_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    evtValid |-> (evtCode >= EVT_EXPIRE && evtCode <= EVT_STAT)); // R8
  AST_IDLE_NO_EVT: assert property (@(posedge clk) disable iff (!rst_n)
    !anyPend |=> !evtValid); // R8
endmodule

// File: rtl/hold_wd_dpath.sv
module hold_wd_dpath
  import hold_wd_pkg::*;
#(
  parameter logic [TMO_W-1:0] TMO_RESET = TMO_W'(3)
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  wdStrobes_t                strb,
  input  logic [NUM_CONS*TMO_W-1:0] tmoFlat,
  input  logic                      cycleTick,
  input  logic [NUM_CONS-1:0]       frameOk,
  output logic [NUM_CONS-1:0]       expireNow,
  output logic [NUM_CONS-1:0]       consStatus,
  output logic [NUM_CONS-1:0]       expireFlags,
  output logic [NUM_PROV-1:0]       provActive
);
  logic [TMO_W-1:0]    timer  [NUM_CONS];
  logic [TMO_W-1:0]    tmoArr [NUM_CONS];
  logic [NUM_CONS-1:0] statusQ;
  logic [NUM_CONS-1:0] expQ;
  logic [NUM_PROV-1:0] provQ;
  logic [NUM_PROV-1:0] shdQ;

  always_comb begin
    for (int i = 0; i < NUM_CONS; i++) begin
      tmoArr[i]    = tmoFlat[i*TMO_W +: TMO_W];
      // a frame in the same cycle beats the tick
      expireNow[i] = strb.active[i] && !frameOk[i] && cycleTick &&
                     statusQ[i] && (timer[i] <= TMO_W'(1));
    end
  end

  // ---------------- hold timers ----------------
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_CONS; i++) timer[i] <= TMO_RESET;
      statusQ <= '1;
      expQ    <= '0;
    end else begin
      for (int i = 0; i < NUM_CONS; i++) begin
        if (strb.actRise[i]) begin
          timer[i]   <= tmoArr[i];
          statusQ[i] <= 1'b1;
          expQ[i]    <= 1'b0;
        end else if (!strb.active[i]) begin
          timer[i] <= tmoArr[i];
        end else if (frameOk[i]) begin
          timer[i]   <= tmoArr[i];
          statusQ[i] <= 1'b1;
        end else if (cycleTick) begin
          if (expireNow[i]) begin
            timer[i]   <= '0;
            statusQ[i] <= 1'b0;
            expQ[i]    <= 1'b1;
          end else if (timer[i] > TMO_W'(1)) begin
            timer[i] <= timer[i] - TMO_W'(1);
          end
        end
      end
    end
  end

  // ---------------- provider active / shadow bits ----------------
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      provQ <= '0;
      shdQ  <= '0;
    end else begin
      for (int p = 0; p < NUM_PROV; p++) begin
        if (strb.killMask[p]) begin
          provQ[p] <= 1'b0;
          shdQ[p]  <= 1'b0;
        end else begin
          if (strb.provWr[p])  provQ[p] <= strb.wrBit;
          else if (strb.swap)  provQ[p] <= shdQ[p];
          if (strb.shadowWr[p]) shdQ[p] <= strb.wrBit;
        end
      end
    end
  end

  assign consStatus  = statusQ;
  assign expireFlags = expQ;
  assign provActive  = provQ;

  AST_EXPIRE_FAILS: assert property (@(posedge clk) disable iff (!rst_n)
    (expireNow != '0) |=> (((consStatus & $past(expireNow)) == '0) &&
                           ((expireFlags & $past(expireNow)) == $past(expireNow)))); // R4
  AST_KILL_CLEARS_PROV: assert property (@(posedge clk) disable iff (!rst_n)
    (strb.killMask != '0) |=> ((provActive & $past(strb.killMask)) == '0)); // R6
  AST_KILL_CLEARS_SHADOW: assert property (@(posedge clk) disable iff (!rst_n)
    (strb.killMask != '0) |=> ((shdQ & $past(strb.killMask)) == '0)); // R7
  AST_RISE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (strb.actRise != '0) |=> (((expireFlags & $past(strb.actRise)) == '0) &&
                              ((consStatus & $past(strb.actRise)) == $past(strb.actRise)))); // R3
  AST_FRAME_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    ((frameOk & strb.active) != '0) |=>
      ((consStatus & $past(frameOk & strb.active)) == $past(frameOk & strb.active))); // R5
endmodule

// File: rtl/hold_watchdog.sv
module hold_watchdog
  import hold_wd_pkg::*;
#(
  parameter logic [TMO_W-1:0]    TMO_RESET  = TMO_W'(3),
  parameter logic [NUM_PROV-1:0] MASK_RESET = '1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                hostWe,
  input  logic [ADDR_W-1:0]   hostAddr,
  input  logic [7:0]          hostWdata,
  input  logic                listSwap,
  input  logic                cycleTick,
  input  logic [NUM_CONS-1:0] frameOk,
  input  logic [NUM_CONS-1:0] crcErr,
  input  logic [NUM_CONS-1:0] seqErr,
  input  logic [NUM_CONS-1:0] statErr,
  output logic [NUM_CONS-1:0] consStatus,
  output logic [NUM_CONS-1:0] expireFlags,
  output logic [NUM_PROV-1:0] provActive,
  output logic                evtValid,
  output logic [7:0]          evtCode,
  output logic [CIDX_W-1:0]   evtCons
);
  wdStrobes_t                strb;
  logic [NUM_CONS*TMO_W-1:0] tmoFlat;
  logic [NUM_CONS-1:0]       expireNow;

  hold_wd_ctrl #(.TMO_RESET(TMO_RESET), .MASK_RESET(MASK_RESET)) ctrl_i (
    .clk(clk), .rst_n(rst_n), .hostWe(hostWe), .hostAddr(hostAddr),
    .hostWdata(hostWdata), .listSwap(listSwap), .crcErr(crcErr),
    .seqErr(seqErr), .statErr(statErr), .expireNow(expireNow),
    .strb(strb), .tmoFlat(tmoFlat), .evtValid(evtValid),
    .evtCode(evtCode), .evtCons(evtCons)
  );

  hold_wd_dpath #(.TMO_RESET(TMO_RESET)) dpath_i (
    .clk(clk), .rst_n(rst_n), .strb(strb), .tmoFlat(tmoFlat),
    .cycleTick(cycleTick), .frameOk(frameOk), .expireNow(expireNow),
    .consStatus(consStatus), .expireFlags(expireFlags), .provActive(provActive)
  );
endmodule

// File: tb/hold_watchdog_tb_top.sv
module hold_watchdog_tb_top;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic       rst_n, hostWe, listSwap, cycleTick;
  logic [5:0] hostAddr;
  logic [7:0] hostWdata, frameOk, crcErr, seqErr, statErr;
  logic [7:0] consStatus, expireFlags, provActive, evtCode;
  logic       evtValid;
  logic [2:0] evtCons;

  hold_watchdog dut_i (
    .clk(clk), .rst_n(rst_n), .hostWe(hostWe), .hostAddr(hostAddr),
    .hostWdata(hostWdata), .listSwap(listSwap), .cycleTick(cycleTick),
    .frameOk(frameOk), .crcErr(crcErr), .seqErr(seqErr), .statErr(statErr),
    .consStatus(consStatus), .expireFlags(expireFlags), .provActive(provActive),
    .evtValid(evtValid), .evtCode(evtCode), .evtCons(evtCons)
  );

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit done   = 0;
  bit cmpOn  = 0;

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  int       mTmo[8], mGrp[8], mMask[8], mTim[8];
  bit [7:0] mAct, mSt, mExp, mPa, mPs;
  bit [7:0] mPend[4];
  bit       mEvV;
  int       mEvC, mEvI;

  always @(posedge clk) begin : model
    bit [7:0] rise, kill, oldPs, sel;
    bit [7:0] nw[4];
    bit       f;
    int       fc, fi, region, idx;
    if (!rst_n) begin
      for (int i = 0; i < 8; i++) begin
        mTmo[i] = 3; mGrp[i] = 0; mMask[i] = 8'hFF; mTim[i] = 3;
      end
      mAct = 0; mSt = 8'hFF; mExp = 0; mPa = 0; mPs = 0;
      for (int c = 0; c < 4; c++) mPend[c] = 0;
      mEvV = 0; mEvC = 0; mEvI = 0;
    end else begin
      region = int'(hostAddr[5:3]);
      idx    = int'(hostAddr[2:0]);
      rise = (hostWe && region == 1 && idx == 0) ? (hostWdata & ~mAct) : 8'h00;
      kill = 0;
      nw[0] = 0;
      for (int i = 0; i < 8; i++) begin
        if (rise[i]) begin
          mTim[i] = mTmo[i]; mSt[i] = 1; mExp[i] = 0;
        end else if (!mAct[i]) begin
          mTim[i] = mTmo[i];
        end else if (frameOk[i]) begin
          mTim[i] = mTmo[i]; mSt[i] = 1;
        end else if (cycleTick) begin
          if (mSt[i] && mTim[i] <= 1) begin
            nw[0][i] = 1; mTim[i] = 0; mSt[i] = 0; mExp[i] = 1;
            kill = kill | ~8'(mMask[mGrp[i]]);
          end else if (mTim[i] > 1) mTim[i] = mTim[i] - 1;
        end
      end
      nw[1] = crcErr & mAct; nw[2] = seqErr & mAct; nw[3] = statErr & mAct;
      f = 0; fc = 0; fi = 0;
      for (int c = 0; c < 4; c++)
        for (int i = 0; i < 8; i++)
          if (!f && mPend[c][i]) begin f = 1; fc = c; fi = i; end
      mEvV = f; mEvC = f ? fc + 1 : 0; mEvI = f ? fi : 0;
      for (int c = 0; c < 4; c++) begin
        sel = (f && fc == c) ? (8'h01 << fi) : 8'h00;
        mPend[c] = (mPend[c] & ~sel) | nw[c];
      end
      oldPs = mPs;
      for (int p = 0; p < 8; p++) begin
        if (kill[p]) begin
          mPa[p] = 0; mPs[p] = 0;
        end else begin
          if (hostWe && region == 4 && idx == p) mPa[p] = hostWdata[0];
          else if (listSwap) mPa[p] = oldPs[p];
          if (hostWe && region == 5 && idx == p) mPs[p] = hostWdata[0];
        end
      end
      if (hostWe) begin
        case (region)
          0: mTmo[idx] = int'(hostWdata);
          1: if (idx == 0) mAct = hostWdata;
          2: mGrp[idx] = int'(hostWdata[2:0]);
          3: mMask[idx] = int'(hostWdata);
          default: ;
        endcase
      end
    end
  end

  always @(negedge clk) begin
    if (cmpOn && !done) begin
      chk("R4 R5 consumer status vs model", int'(consStatus), int'(mSt));
      chk("R3 R4 expire flags vs model", int'(expireFlags), int'(mExp));
      chk("R6 R7 provider active vs model", int'(provActive), int'(mPa));
      chk("R8 R9 event valid vs model", int'(evtValid), int'(mEvV));
      chk("R8 event code vs model", int'(evtCode), mEvC);
      chk("R8 event consumer vs model", int'(evtCons), mEvI);
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic hw(int a, int d);
    hostWe = 1; hostAddr = 6'(a); hostWdata = 8'(d);
    @(negedge clk);
    hostWe = 0;
  endtask

  task automatic step(bit tk, bit [7:0] fr, bit sw);
    cycleTick = tk; frameOk = fr; listSwap = sw;
    @(negedge clk);
    cycleTick = 0; frameOk = 0; listSwap = 0; crcErr = 0; seqErr = 0; statErr = 0;
  endtask

  task automatic summary();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000 && !done) begin
      errors++;
      $display("FAIL R1 watchdog expired actual=%0d expected<=100000", cycles);
      summary();
    end
  end

  initial begin
    rst_n = 0; hostWe = 0; hostAddr = 0; hostWdata = 0; listSwap = 0;
    cycleTick = 0; frameOk = 0; crcErr = 0; seqErr = 0; statErr = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    cmpOn = 1;
    chk("R1 reset status", int'(consStatus), 8'hFF);
    chk("R1 reset expire", int'(expireFlags), 0);
    chk("R1 reset providers", int'(provActive), 0);
    chk("R1 reset event", int'(evtValid), 0);

    // configuration
    hw(6'h00, 3); hw(6'h01, 5); hw(6'h02, 0);
    hw(6'h10, 1); hw(6'h11, 2); hw(6'h12, 3);
    hw(6'h19, 8'hF0); hw(6'h1A, 8'hCF);
    for (int p = 0; p < 8; p++) begin
      hw(6'h20 + p, 1);
      hw(6'h28 + p, 1);
    end
    chk("R2 provider bits written", int'(provActive), 8'hFF);

    // unmapped writes and inactive consumers
    hw(6'h09, 8'hFF); hw(6'h38, 8'hFF); hw(6'h30, 8'h00);
    for (int k = 0; k < 5; k++) step(1, 8'h00, 0);
    chk("R2 unmapped writes ignored", int'(expireFlags), 0);
    chk("R3 inactive never expires", int'(consStatus), 8'hFF);
    chk("R2 providers untouched", int'(provActive), 8'hFF);
    crcErr = 8'h08; seqErr = 8'h01;
    step(0, 8'h00, 0);
    @(negedge clk);
    chk("R9 inactive errors not posted", int'(evtValid), 0);
    @(negedge clk);
    chk("R9 inactive errors not posted", int'(evtValid), 0);

    // activate consumers 0..2
    hw(6'h08, 8'h07);
    step(1, 8'h02, 0);
    chk("R4 zero timeout expires on first tick", int'(expireFlags), 8'h04);
    chk("R6 empty group leaves providers", int'(provActive), 8'hFF);
    step(0, 8'h00, 0);
    chk("R8 expiry event valid", int'(evtValid), 1);
    chk("R8 expiry code", int'(evtCode), 1);
    chk("R8 expiry consumer", int'(evtCons), 2);
    step(1, 8'h02, 0);
    chk("R4 not yet expired after two ticks", int'(consStatus), 8'hFB);
    step(1, 8'h02, 0);
    chk("R4 third tick expires timeout 3", int'(consStatus), 8'hFA);
    chk("R4 expire flags", int'(expireFlags), 8'h05);
    chk("R6 group members withdrawn", int'(provActive), 8'hF0);
    step(0, 8'h00, 0);
    chk("R8 second expiry consumer", int'(evtCons), 0);

    // frame and tick together
    for (int k = 0; k < 4; k++) step(1, 8'h00, 0);
    step(1, 8'h02, 0);
    chk("R5 frame beats tick", int'(consStatus), 8'hFA);
    for (int k = 0; k < 4; k++) step(1, 8'h00, 0);
    chk("R5 reload restarted count", int'(consStatus), 8'hFA);
    step(1, 8'h00, 1);
    chk("R4 timeout 5 expires", int'(consStatus), 8'hF8);
    chk("R7 kill beats same-cycle swap", int'(provActive), 8'hC0);
    step(0, 8'h00, 1);
    chk("R7 shadow cleared by kill", int'(provActive), 8'hC0);

    // reactivation
    hw(6'h08, 0);
    hw(6'h08, 8'h07);
    chk("R3 reactivation clears expire", int'(expireFlags), 0);
    chk("R3 reactivation restores run", int'(consStatus), 8'hFF);

    // event ordering and merging
    repeat (3) @(negedge clk);
    crcErr = 8'h06; seqErr = 8'h01; statErr = 8'h80;
    step(0, 8'h00, 0);
    chk("R8 queued not yet posted", int'(evtValid), 0);
    @(negedge clk);
    chk("R8 order first code", int'(evtCode), 2);
    chk("R8 order first consumer", int'(evtCons), 1);
    @(negedge clk);
    chk("R8 order second consumer", int'(evtCons), 2);
    @(negedge clk);
    chk("R8 order third code", int'(evtCode), 3);
    @(negedge clk);
    chk("R9 inactive status error dropped", int'(evtValid), 0);

    // random traffic against the model
    for (int k = 0; k < 3000; k++) begin
      hostWe = ($urandom % 10) == 0;
      hostAddr = 6'($urandom % 48);
      hostWdata = 8'($urandom);
      if (hostAddr[5:3] == 3'd0) hostWdata = 8'($urandom % 6);
      cycleTick = ($urandom % 3) == 0;
      frameOk = 8'($urandom) & 8'($urandom) & 8'($urandom);
      crcErr = (($urandom % 8) == 0) ? 8'($urandom) : 8'h00;
      seqErr = (($urandom % 8) == 0) ? 8'($urandom) : 8'h00;
      statErr = (($urandom % 8) == 0) ? 8'($urandom) : 8'h00;
      listSwap = ($urandom % 16) == 0;
      @(negedge clk);
    end
    hostWe = 0; cycleTick = 0; frameOk = 0; crcErr = 0; seqErr = 0; statErr = 0; listSwap = 0;
    @(negedge clk);
    summary();
  end
endmodule